// File: doc/BRIEF.md
# Pending Interrupt Delivery Controller

This block sits between external interrupt sources and a processor core and decides when the core takes an exception. It captures three kinds of request events: a reset request, a non-maskable interrupt request, and a maskable interrupt level. It keeps each one as a pending flag until the core reports an instruction boundary through a one-cycle strobe. At each boundary it serves at most one pending request, chosen by a fixed priority.

A served reset or NMI request produces a pulse on a single shared exception output. A served maskable level is copied into the hardware-interrupt field of the cause register, which the block exposes as an output. The level raises the interrupt exception only when the status enable input is high and the level shares at least one set bit with the status mask input. A level that is not yet allowed stays pending and is tried again at every later boundary. A level event carrying zero is a withdrawal: at the next served boundary it clears the cause field and raises nothing.

All outputs are registered. They change on the clock edge that samples the boundary strobe, so they are visible in the cycle after the strobe.

Top module: `irq_deliver_ctrl`

## Requirements
- R1: After synchronous reset, `cause_ip_o` is zero, both exception outputs are low and nothing is pending, so a boundary with no new events raises no exception.
- R2: A reset request event is served at a later boundary. In the cycle after that boundary strobe, `rn_exc_o` is high for exactly one cycle.
- R3: An NMI request event is served on the same `rn_exc_o` output. Repeated reset or NMI events of one kind that arrive before it is served merge into one pulse.
- R4: One request is served per boundary, in this order: reset first, then NMI, then the maskable level. Serving reset or NMI leaves `cause_ip_o` unchanged and keeps a pending level waiting.
- R5: When a nonzero pending level is served, `cause_ip_o` holds that level from the cycle after the boundary.
- R6: A served nonzero level pulses `int_exc_o` only if `irq_en_i` is 1 and (level AND `irq_mask_i`) is nonzero. Delivery clears the pending level, so the next boundary raises nothing.
- R7: A nonzero level that is disabled or fully masked stays pending. It is re-evaluated at each following boundary and is delivered once enable and mask allow it.
- R8: A level event with value zero, once served, sets `cause_ip_o` to zero, raises no exception and removes any pending level.
- R9: A newer level event replaces an older level that has not been delivered.
- R10: Without a boundary strobe, `cause_ip_o` does not change and no exception pulse appears, even while events arrive.
- R11: An event that arrives in the same cycle as a boundary strobe is not served by that boundary and stays pending for the next one. The request served at that boundary is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | One-cycle instruction boundary strobe |
| rst_req_i | input | 1 | Reset request event |
| nmi_req_i | input | 1 | Non-maskable interrupt request event |
| lvl_evt_i | input | 1 | Maskable level event strobe |
| lvl_val_i | input | IP_W | Level value carried by the event; zero means withdrawal |
| irq_en_i | input | 1 | Status global interrupt enable |
| irq_mask_i | input | IP_W | Status interrupt mask field |
| cause_ip_o | output | IP_W | Cause register hardware-interrupt field |
| rn_exc_o | output | 1 | Combined reset/NMI exception pulse |
| int_exc_o | output | 1 | Maskable interrupt exception pulse |

## Verification
The bench sweeps every nonzero level against every mask value with the enable both off and on. A design with a wrong enable test would fire on a masked or disabled level, or would never retry it. A one-shot design would lose the level, and one that does not clear on delivery would fire twice. Directed cases stack reset, NMI and a level together: reversed priority would show the level pulse first or a changed cause field. They also check that repeated NMI events collapse into one pulse, and that a zero level wipes both the cause field and the pending request. Events that land on the boundary cycle itself are checked too. A design that lets the clear win would drop the new request, and one that serves it at once would deliver the wrong level.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int IRQD_IP_W = 6;

    // Meaning of the stored maskable-level slot
    typedef enum logic [1:0] {
        LK_NONE    = 2'd0,
        LK_CLEARED = 2'd1,
        LK_REQ     = 2'd2
    } lvl_kind_e;

    // Source served at a boundary
    typedef enum logic [2:0] {
        SEL_IDLE = 3'd0,
        SEL_RST  = 3'd1,
        SEL_NMI  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_LVL  = 3'd4
    } sel_e;

    // Fixed priority: reset, then NMI, then the level slot
    function automatic sel_e pick_source(input logic rst_p, input logic nmi_p,
                                         input lvl_kind_e kind);
        sel_e s;
        if (rst_p)                    s = SEL_RST;
        else if (nmi_p)               s = SEL_NMI;
        else if (kind == LK_CLEARED)  s = SEL_CLR;
        else if (kind == LK_REQ)      s = SEL_LVL;
        else                          s = SEL_IDLE;
        return s;
    endfunction

endpackage

// File: rtl/irqd_pending.sv
module irqd_pending
    import irqd_pkg::*;
#(
    parameter int IP_W = IRQD_IP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rst_evt,
    input  logic            nmi_evt,
    input  logic            lvl_evt,
    input  logic [IP_W-1:0] lvl_val,
    input  logic            boundary,
    input  sel_e            sel,
    input  logic            lvl_hit,
    output logic            rst_pend,
    output logic            nmi_pend,
    output lvl_kind_e       lvl_kind,
    output logic [IP_W-1:0] lvl_pend
);

    logic take_rst, take_nmi, take_lvl;

    always_comb begin
        take_rst = boundary && (sel == SEL_RST);
        take_nmi = boundary && (sel == SEL_NMI);
        take_lvl = boundary && ((sel == SEL_CLR) || ((sel == SEL_LVL) && lvl_hit));
    end

    // A new event in the serving cycle wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
            lvl_kind <= LK_NONE;
            lvl_pend <= '0;
        end else begin
            rst_pend <= rst_evt | (rst_pend & ~take_rst);
            nmi_pend <= nmi_evt | (nmi_pend & ~take_nmi);
            if (lvl_evt) begin
                lvl_kind <= (lvl_val == '0) ? LK_CLEARED : LK_REQ;
                lvl_pend <= lvl_val;
            end else if (take_lvl) begin
                lvl_kind <= LK_NONE;
            end
        end
    end

endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int IP_W = IRQD_IP_W
) (
    input  logic            rst_pend,
    input  logic            nmi_pend,
    input  lvl_kind_e       lvl_kind,
    input  logic [IP_W-1:0] lvl_pend,
    input  logic            irq_en,
    input  logic [IP_W-1:0] irq_mask,
    output sel_e            sel,
    output logic            lvl_hit
);

    always_comb begin
        sel     = pick_source(rst_pend, nmi_pend, lvl_kind);
        lvl_hit = irq_en && ((lvl_pend & irq_mask) != '0);
    end

endmodule

// File: rtl/irqd_cause.sv
module irqd_cause
    import irqd_pkg::*;
#(
    parameter int IP_W = IRQD_IP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary,
    input  sel_e            sel,
    input  logic            lvl_hit,
    input  logic [IP_W-1:0] lvl_pend,
    output logic [IP_W-1:0] cause_ip,
    output logic            rn_exc,
    output logic            int_exc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_ip <= '0;
            rn_exc   <= 1'b0;
            int_exc  <= 1'b0;
        end else begin
            rn_exc  <= 1'b0;
            int_exc <= 1'b0;
            if (boundary) begin
                unique case (sel)
                    SEL_RST, SEL_NMI: rn_exc <= 1'b1;
                    SEL_CLR:          cause_ip <= '0;
                    SEL_LVL: begin
                        cause_ip <= lvl_pend;
                        int_exc  <= lvl_hit;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_CLR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (boundary && sel == SEL_CLR) |=> (cause_ip == '0 && !int_exc && !rn_exc)); // R8

    AST_RN_SKIPS_IP: assert property (@(posedge clk) disable iff (rst)
        (boundary && (sel == SEL_RST || sel == SEL_NMI)) |=> $stable(cause_ip)); // R4

endmodule

// File: rtl/irq_deliver_ctrl.sv
module irq_deliver_ctrl
    import irqd_pkg::*;
#(
    parameter int IP_W = IRQD_IP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary_i,
    input  logic            rst_req_i,
    input  logic            nmi_req_i,
    input  logic            lvl_evt_i,
    input  logic [IP_W-1:0] lvl_val_i,
    input  logic            irq_en_i,
    input  logic [IP_W-1:0] irq_mask_i,
    output logic [IP_W-1:0] cause_ip_o,
    output logic            rn_exc_o,
    output logic            int_exc_o
);

    logic            rst_pend, nmi_pend, lvl_hit;
    lvl_kind_e       lvl_kind;
    logic [IP_W-1:0] lvl_pend;
    sel_e            sel;

    irqd_pending #(.IP_W(IP_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .rst_evt  (rst_req_i),
        .nmi_evt  (nmi_req_i),
        .lvl_evt  (lvl_evt_i),
        .lvl_val  (lvl_val_i),
        .boundary (boundary_i),
        .sel      (sel),
        .lvl_hit  (lvl_hit),
        .rst_pend (rst_pend),
        .nmi_pend (nmi_pend),
        .lvl_kind (lvl_kind),
        .lvl_pend (lvl_pend)
    );

    irqd_arbiter #(.IP_W(IP_W)) u_arb (
        .rst_pend (rst_pend),
        .nmi_pend (nmi_pend),
        .lvl_kind (lvl_kind),
        .lvl_pend (lvl_pend),
        .irq_en   (irq_en_i),
        .irq_mask (irq_mask_i),
        .sel      (sel),
        .lvl_hit  (lvl_hit)
    );

    irqd_cause #(.IP_W(IP_W)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary_i),
        .sel      (sel),
        .lvl_hit  (lvl_hit),
        .lvl_pend (lvl_pend),
        .cause_ip (cause_ip_o),
        .rn_exc   (rn_exc_o),
        .int_exc  (int_exc_o)
    );

    // One cycle after reset release, so that $past/$stable see valid history
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_ONE_EXC_KIND: assert property (@(posedge clk) disable iff (rst)
        !(rn_exc_o && int_exc_o)); // R4

    AST_RN_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
        rn_exc_o |-> $past(boundary_i)); // R2

    AST_IP_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(boundary_i) |-> ($stable(cause_ip_o) && !int_exc_o)); // R10

    AST_INT_ALLOWED: assert property (@(posedge clk) disable iff (rst || !armed)
        int_exc_o |-> ($past(irq_en_i) && (($past(irq_mask_i) & cause_ip_o) != '0))); // R6

endmodule

// File: tb/sim_irq_deliver_ctrl.sv
module sim_irq_deliver_ctrl;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         boundary_i = 1'b0;
    logic         rst_req_i = 1'b0;
    logic         nmi_req_i = 1'b0;
    logic         lvl_evt_i = 1'b0;
    logic [W-1:0] lvl_val_i = '0;
    logic         irq_en_i = 1'b0;
    logic [W-1:0] irq_mask_i = '0;
    logic [W-1:0] cause_ip_o;
    logic         rn_exc_o;
    logic         int_exc_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    irq_deliver_ctrl #(.IP_W(W)) u0 (
        .clk(clk), .rst(rst), .boundary_i(boundary_i),
        .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
        .lvl_evt_i(lvl_evt_i), .lvl_val_i(lvl_val_i),
        .irq_en_i(irq_en_i), .irq_mask_i(irq_mask_i),
        .cause_ip_o(cause_ip_o), .rn_exc_o(rn_exc_o), .int_exc_o(int_exc_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input int ip, input int rn, input int it);
        chk(req, int'(cause_ip_o), ip);
        chk(req, int'(rn_exc_o), rn);
        chk(req, int'(int_exc_o), it);
    endtask

    task automatic bstep();
        boundary_i = 1'b1;
        tick();
        boundary_i = 1'b0;
    endtask

    task automatic lvl_ev(input logic [W-1:0] v);
        lvl_evt_i = 1'b1;
        lvl_val_i = v;
        tick();
        lvl_evt_i = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 200000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        outs("R1 reset state", 0, 0, 0);
        bstep();
        outs("R1 idle boundary", 0, 0, 0);

        // R2: reset request
        rst_req_i = 1'b1; tick(); rst_req_i = 1'b0;
        tick();
        outs("R2 no strobe yet", 0, 0, 0);
        bstep();
        outs("R2 rn pulse", 0, 1, 0);
        tick();
        outs("R2 pulse single cycle", 0, 0, 0);
        bstep();
        outs("R2 served once", 0, 0, 0);

        // R3: NMI merge
        nmi_req_i = 1'b1; tick(); tick(); nmi_req_i = 1'b0;
        tick();
        nmi_req_i = 1'b1; tick(); nmi_req_i = 1'b0;
        bstep();
        outs("R3 nmi pulse", 0, 1, 0);
        bstep();
        outs("R3 merged", 0, 0, 0);

        // R4: priority with all three pending
        irq_en_i = 1'b1; irq_mask_i = '1;
        rst_req_i = 1'b1; nmi_req_i = 1'b1; lvl_evt_i = 1'b1; lvl_val_i = 6'h05;
        tick();
        rst_req_i = 1'b0; nmi_req_i = 1'b0; lvl_evt_i = 1'b0;
        bstep();
        outs("R4 reset first", 0, 1, 0);
        bstep();
        outs("R4 nmi second", 0, 1, 0);
        bstep();
        outs("R4 level third", 5, 0, 1);
        bstep();
        outs("R4 nothing left", 5, 0, 0);

        // R9: overwrite
        lvl_ev(6'h09);
        lvl_ev(6'h30);
        bstep();
        outs("R9 newer level", 48, 0, 1);

        // R8: zero level withdraws a waiting request
        irq_en_i = 1'b0;
        lvl_ev(6'h11);
        bstep();
        outs("R8 setup disabled", 17, 0, 0);
        lvl_ev(6'h00);
        bstep();
        outs("R8 cleared", 0, 0, 0);
        irq_en_i = 1'b1;
        bstep();
        outs("R8 nothing pending", 0, 0, 0);

        // R11: event on the boundary cycle
        lvl_ev(6'h03);
        lvl_evt_i = 1'b1; lvl_val_i = 6'h28;
        bstep();
        lvl_evt_i = 1'b0;
        outs("R11 old served", 3, 0, 1);
        bstep();
        outs("R11 new kept", 40, 0, 1);
        nmi_req_i = 1'b1;
        bstep();
        nmi_req_i = 1'b0;
        outs("R11 nmi not served same cycle", 40, 0, 0);
        bstep();
        outs("R11 nmi next boundary", 40, 1, 0);

        // R10: no strobe, no change
        lvl_ev(6'h07);
        rst_req_i = 1'b1; tick(); rst_req_i = 1'b0;
        repeat (4) tick();
        outs("R10 quiet", 40, 0, 0);
        bstep();
        outs("R10 reset served", 40, 1, 0);
        bstep();
        outs("R10 level served", 7, 0, 1);

        // R5/R6/R7: sweep levels x mask x enable
        for (int lv = 1; lv < 64; lv++) begin
            for (int en = 0; en < 2; en++) begin
                for (int mk = 0; mk < 64; mk++) begin
                    int exp_hit;
                    exp_hit = ((en == 1) && ((lv & mk) != 0)) ? 1 : 0;
                    lvl_ev(W'(lv));
                    irq_en_i = en[0];
                    irq_mask_i = W'(mk);
                    bstep();
                    outs("R5 R6 sweep", lv, 0, exp_hit);
                    if (exp_hit == 0) begin
                        irq_en_i = 1'b1;
                        irq_mask_i = '1;
                        bstep();
                        outs("R7 retry delivers", lv, 0, 1);
                    end
                    bstep();
                    chk("R6 cleared after delivery", int'(int_exc_o), 0);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule